// File: doc/BRIEF.md
# Double-buffered asynchronous serial transmitter

This block turns parallel words into asynchronous serial frames on a single output line. A frame is a low start bit, then 5 to 9 data bits sent either least or most significant bit first, then an optional even or odd parity bit, then one or two high stop bits. Bit timing comes from an external baud tick, which is a one-cycle pulse per bit time. The block does not generate the baud rate and has no receive path.

Each accepted word is held in a holding register together with the line settings present on the configuration inputs when the word was written. The shifter takes the word from the holding register at a baud tick. While one frame is on the line, the next word can be written. That word is loaded at the tick that ends the last stop bit, so the next start bit follows with no idle time.

Two status outputs serve the producer. `dre` is high while the holding register can accept a word. `txc` goes high once the last stop bit has left the line with nothing waiting behind it. `txc` stays high until it is cleared by a one on `txc_clr` or by an accepted write.

Top module: `dbuf_serial_tx`

## Requirements
- R1: After reset, `tx_line` is 1, `dre` is 1 and `txc` is 0.
- R2: `tx_line` changes only in the cycle after a `baud_tick` pulse. A frame is a 0 start bit, then the data bits, then the parity bit if enabled, then stop bits at 1. Each bit lasts from one tick to the next. Between frames the line is 1.
- R3: `cfg_len` codes 0, 1, 2, 3 and 4 select 5, 6, 7, 8 and 9 data bits. Codes 5, 6 and 7 select 9 data bits. Data bits are taken from the low end of `wr_data`.
- R4: With `cfg_par_en`=1, a parity bit follows the last data bit. With `cfg_par_odd`=0 it is the XOR of the data bits sent (even parity). With `cfg_par_odd`=1 it is the inverse (odd parity). With `cfg_par_en`=0, no parity bit is sent.
- R5: `cfg_stop2`=0 sends one stop bit and `cfg_stop2`=1 sends two.
- R6: `cfg_msb_first`=0 sends `wr_data[0]` first. `cfg_msb_first`=1 sends the highest selected data bit first.
- R7: A write (`wr_en`=1) while `dre`=1 is accepted, and `dre` is 0 in the following cycle. At the next tick the word moves into an idle shifter. Its start bit begins at that tick, and `dre` returns to 1 in the cycle after it.
- R8: A write while `dre`=0 is ignored. The word is never transmitted, and `dre` stays 0 until the stored word moves into the shifter at a tick.
- R9: If a word is waiting when the final stop bit ends, its start bit begins at that same tick, with no idle bit between the frames.
- R10: `txc` rises in the cycle after the tick that ends a frame with the holding register empty. An accepted write clears it, and takes priority over that set. `txc_clr`=1 also clears it, but the set takes priority over `txc_clr`. While `txc` is 1, `tx_line` and `dre` are both 1.
- R11: The frame settings (`cfg_len`, `cfg_par_en`, `cfg_par_odd`, `cfg_stop2`, `cfg_msb_first`) are captured together with the word at the write. Later changes on those inputs do not affect that word's frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send, LSB-aligned |
| cfg_len | input | 3 | Data length code (see R3) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cfg_msb_first | input | 1 | 1 sends the most significant data bit first |
| txc_clr | input | 1 | Write-one clear of `txc` |
| tx_line | output | 1 | Serial output, idles high |
| dre | output | 1 | Holding register empty |
| txc | output | 1 | Transmit complete |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse with at least one idle cycle between pulses. Under that assumption, a write accepted at one edge can never be loaded into the shifter at the same edge. The bench drives a tick every fourth cycle and places every write in the cycle right after a tick. Each write therefore lands clear of a tick, and its start bit is due exactly one tick later. Configuration inputs change only away from the write cycle, except where the bench deliberately changes them after a write to exercise capture.

// File: rtl/dbuf_serial_tx_pkg.sv
package dbuf_serial_tx_pkg;

    localparam int MIN_DATA   = 5;
    localparam int MAX_DATA   = 9;
    localparam int MAX_STOP   = 2;
    localparam int LEN_CODE_W = 3;
    // start + data + parity + stop bits
    localparam int FRAME_W    = 1 + MAX_DATA + 1 + MAX_STOP;
    localparam int CNT_W      = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [LEN_CODE_W-1:0] len_code;
        logic                  par_en;
        logic                  par_odd;
        logic                  stop2;
        logic                  msb_first;
    } line_cfg_t;

    typedef struct packed {
        logic [MAX_DATA-1:0] data;
        line_cfg_t           cfg;
    } tx_word_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;   // bit 0 leaves the line first
        logic [CNT_W-1:0]   len;
    } tx_frame_t;

    function automatic int data_bits(input logic [LEN_CODE_W-1:0] code);
        if (int'(code) > MAX_DATA - MIN_DATA)
            return MAX_DATA;
        return MIN_DATA + int'(code);
    endfunction

    // Lay a word out in line order, padding unused tail positions with idle 1s.
    function automatic tx_frame_t build_frame(input tx_word_t w);
        tx_frame_t f;
        int        n;
        int        pos;
        int        src;
        logic      b;
        logic      par;
        n      = data_bits(w.cfg.len_code);
        f.bits = '1;
        f.bits[0] = 1'b0;
        par    = w.cfg.par_odd;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < n) begin
                src = w.cfg.msb_first ? (n - 1 - i) : i;
                b   = w.data[src];
                par = par ^ b;
                f.bits[1 + i] = b;
            end
        end
        pos = 1 + n;
        if (w.cfg.par_en) begin
            f.bits[pos] = par;
            pos = pos + 1;
        end
        pos   = pos + (w.cfg.stop2 ? 2 : 1);
        f.len = CNT_W'(pos);
        return f;
    endfunction

endpackage

// File: rtl/sertx_holding.sv
module sertx_holding
    import dbuf_serial_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  tx_word_t wr_word,
    input  logic     pop,
    output logic     full,
    output logic     accept,
    output tx_word_t word
);

    assign accept = wr_en & ~full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
        end else begin
            if (accept) begin
                full <= 1'b1;
                word <= wr_word;
            end else if (pop) begin
                full <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import dbuf_serial_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     hold_full,
    input  tx_word_t hold_word,
    output logic     pop,
    output logic     frame_done,
    output logic     line
);

    logic               active;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   left;
    logic               on_last;
    logic               can_load;
    tx_frame_t          next_frame;

    always_comb next_frame = build_frame(hold_word);

    assign on_last    = active && (left == CNT_W'(1));
    assign can_load   = !active || on_last;
    assign pop        = tick && can_load && hold_full;
    assign frame_done = tick && on_last && !hold_full;
    assign line       = active ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            shreg  <= '1;
            left   <= '0;
        end else if (tick) begin
            if (pop) begin
                active <= 1'b1;
                shreg  <= next_frame.bits;
                left   <= next_frame.len;
            end else if (on_last) begin
                active <= 1'b0;
                shreg  <= '1;
                left   <= '0;
            end else if (active) begin
                shreg  <= {1'b1, shreg[FRAME_W-1:1]};
                left   <= left - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/sertx_status.sv
module sertx_status (
    input  logic clk,
    input  logic rst,
    input  logic frame_done,
    input  logic accept,
    input  logic clr,
    output logic txc
);

    // Priority: accepted write clears, then end of frame sets, then clear strobe.
    always_ff @(posedge clk) begin
        if (rst)             txc <= 1'b0;
        else if (accept)     txc <= 1'b0;
        else if (frame_done) txc <= 1'b1;
        else if (clr)        txc <= 1'b0;
    end

endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
    import dbuf_serial_tx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  baud_tick,
    input  logic                  wr_en,
    input  logic [MAX_DATA-1:0]   wr_data,
    input  logic [LEN_CODE_W-1:0] cfg_len,
    input  logic                  cfg_par_en,
    input  logic                  cfg_par_odd,
    input  logic                  cfg_stop2,
    input  logic                  cfg_msb_first,
    input  logic                  txc_clr,
    output logic                  tx_line,
    output logic                  dre,
    output logic                  txc
);

    tx_word_t in_word;
    tx_word_t held_word;
    logic     hold_full;
    logic     accept;
    logic     pop;
    logic     frame_done;

    always_comb begin
        in_word.data          = wr_data;
        in_word.cfg.len_code  = cfg_len;
        in_word.cfg.par_en    = cfg_par_en;
        in_word.cfg.par_odd   = cfg_par_odd;
        in_word.cfg.stop2     = cfg_stop2;
        in_word.cfg.msb_first = cfg_msb_first;
    end

    sertx_holding u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_word (in_word),
        .pop     (pop),
        .full    (hold_full),
        .accept  (accept),
        .word    (held_word)
    );

    sertx_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .tick       (baud_tick),
        .hold_full  (hold_full),
        .hold_word  (held_word),
        .pop        (pop),
        .frame_done (frame_done),
        .line       (tx_line)
    );

    sertx_status u_stat (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .accept     (accept),
        .clr        (txc_clr),
        .txc        (txc)
    );

    assign dre = ~hold_full;

endmodule

// File: rtl/dbuf_serial_tx_chk.sv
module dbuf_serial_tx_chk (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic wr_en,
    input logic txc_clr,
    input logic tx_line,
    input logic dre,
    input logic txc
);

    // R2: the line only moves after a tick
    assert_line_moves_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !baud_tick |=> $stable(tx_line));

    // R7: an accepted write fills the holding register
    assert_write_fills_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dre) |=> !dre);

    // R8: a full holding register only drains at a tick, whatever is written
    assert_full_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (!dre && !baud_tick) |=> !dre);

    // R10: an accepted write clears transmit complete
    assert_write_clears_txc_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dre) |=> !txc);

    // R10: the clear strobe wins whenever no frame can end
    assert_clr_clears_txc_R10: assert property (@(posedge clk) disable iff (rst)
        (txc_clr && !baud_tick) |=> !txc);

    // R10: transmit complete implies an idle line and an empty holding register
    assert_txc_means_idle_R10: assert property (@(posedge clk) disable iff (rst)
        txc |-> (tx_line && dre));

    // R1: reset state
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (tx_line && dre && !txc));

endmodule

bind dbuf_serial_tx dbuf_serial_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .baud_tick (baud_tick),
    .wr_en     (wr_en),
    .txc_clr   (txc_clr),
    .tx_line   (tx_line),
    .dre       (dre),
    .txc       (txc)
);

// File: tb/dbuf_serial_tx_bench.sv
module dbuf_serial_tx_bench;

    localparam int TICK_P    = 4;
    localparam int MAX_CYCLE = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic [2:0] cfg_len = '0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic       txc_clr = 1'b0;
    logic       tx_line;
    logic       dre;
    logic       txc;

    int checks = 0;
    int fails  = 0;
    int tcnt   = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dbuf_serial_tx u_dbuf_serial_tx (
        .clk           (clk),
        .rst           (rst),
        .baud_tick     (baud_tick),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .cfg_len       (cfg_len),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_odd   (cfg_par_odd),
        .cfg_stop2     (cfg_stop2),
        .cfg_msb_first (cfg_msb_first),
        .txc_clr       (txc_clr),
        .tx_line       (tx_line),
        .dre           (dre),
        .txc           (txc)
    );

    always @(negedge clk) begin
        if (tcnt == TICK_P - 1) begin
            baud_tick <= 1'b1;
            tcnt      <= 0;
        end else begin
            baud_tick <= 1'b0;
            tcnt      <= tcnt + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > MAX_CYCLE && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, MAX_CYCLE);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Ends at the falling edge after a tick edge.
    task automatic wait_tick();
        do @(posedge clk); while (baud_tick !== 1'b1);
        @(negedge clk);
    endtask

    task automatic set_cfg(input int lc, input bit pe, input bit po, input bit s2, input bit msb);
        cfg_len       = 3'(lc);
        cfg_par_en    = pe;
        cfg_par_odd   = po;
        cfg_stop2     = s2;
        cfg_msb_first = msb;
    endtask

    task automatic write_word(input logic [8:0] d);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pulse_clr();
        txc_clr = 1'b1;
        @(negedge clk);
        txc_clr = 1'b0;
    endtask

    // Expected line sequence worked out from R2..R6, bit 0 sent first.
    function automatic int exp_frame(input logic [8:0] d, input int lc, input bit pe,
                                     input bit po, input bit s2, input bit msb,
                                     output logic [15:0] seq);
        int nd;
        int ones;
        int p;
        logic b;
        nd   = (lc > 4) ? 9 : lc + 5;
        ones = 0;
        seq  = '1;
        seq[0] = 1'b0;
        p    = 1;
        for (int k = 0; k < nd; k++) begin
            b = msb ? d[nd - 1 - k] : d[k];
            seq[p] = b;
            ones = ones + int'(b);
            p++;
        end
        if (pe) begin
            seq[p] = ((ones % 2) == 1) ^ po;
            p++;
        end
        return p + (s2 ? 2 : 1);
    endfunction

    initial begin
        logic [15:0] sa;
        logic [15:0] sb;
        logic [31:0] both;
        int na;
        int nb;
        int errs;
        int bad_at;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(tx_line == 1'b1, "R1 line", int'(tx_line), 1);
        chk(dre == 1'b1, "R1 dre", int'(dre), 1);
        chk(txc == 1'b0, "R1 txc", int'(txc), 0);

        // Sweep over every frame setting: R2 R3 R4 R5 R6 R7 R10
        for (int lc = 0; lc < 8; lc++) begin
            for (int cf = 0; cf < 16; cf++) begin
                for (int pat = 0; pat < 2; pat++) begin
                    logic [8:0] d;
                    d = 9'(9'h155 ^ (lc * 37) ^ (cf * 11));
                    if (pat == 1) d = ~d;
                    set_cfg(lc, cf[0], cf[1], cf[2], cf[3]);
                    na = exp_frame(d, lc, cf[0], cf[1], cf[2], cf[3], sa);
                    wait_tick();
                    write_word(d);
                    chk(dre == 1'b0, "R7 dre low after write", int'(dre), 0);
                    errs = 0;
                    bad_at = -1;
                    for (int k = 0; k < na; k++) begin
                        wait_tick();
                        if (k == 0)
                            chk(dre == 1'b1, "R7 dre high after load", int'(dre), 1);
                        if (tx_line !== sa[k]) begin
                            errs++;
                            if (bad_at < 0) bad_at = k;
                        end
                    end
                    chk(errs == 0, "R2/R3/R4/R5/R6 frame bits (first bad index)", bad_at, -1);
                    wait_tick();
                    chk(txc == 1'b1, "R10 txc after frame", int'(txc), 1);
                    chk(tx_line == 1'b1, "R2 idle after frame", int'(tx_line), 1);
                    pulse_clr();
                    chk(txc == 1'b0, "R10 txc_clr clears", int'(txc), 0);
                end
            end
        end

        // R8: write while full is ignored
        set_cfg(3, 1'b0, 1'b0, 1'b0, 1'b0);
        na = exp_frame(9'h0C3, 3, 1'b0, 1'b0, 1'b0, 1'b0, sa);
        wait_tick();
        write_word(9'h0C3);
        write_word(9'h000);
        chk(dre == 1'b0, "R8 dre stays low", int'(dre), 0);
        errs = 0;
        for (int k = 0; k < na; k++) begin
            wait_tick();
            if (tx_line !== sa[k]) errs++;
        end
        chk(errs == 0, "R8 first word intact", errs, 0);
        for (int k = 0; k < 3; k++) begin
            wait_tick();
            chk(tx_line == 1'b1 && dre == 1'b1, "R8 ignored word never sent",
                int'({tx_line, dre}), 3);
        end
        chk(txc == 1'b1, "R10 txc after ignored write", int'(txc), 1);

        // R10: accepted write clears txc; R9 back to back; R11 capture at write
        set_cfg(4, 1'b1, 1'b1, 1'b1, 1'b1);
        na = exp_frame(9'h1A6, 4, 1'b1, 1'b1, 1'b1, 1'b1, sa);
        nb = exp_frame(9'h02D, 0, 1'b1, 1'b0, 1'b0, 1'b0, sb);
        wait_tick();
        write_word(9'h1A6);
        chk(txc == 1'b0, "R10 write clears txc", int'(txc), 0);
        set_cfg(0, 1'b1, 1'b0, 1'b0, 1'b0);
        both = '1;
        for (int k = 0; k < na; k++) both[k] = sa[k];
        for (int k = 0; k < nb; k++) both[na + k] = sb[k];
        errs = 0;
        bad_at = -1;
        for (int k = 0; k < na + nb; k++) begin
            wait_tick();
            if (k == 0) write_word(9'h02D);
            if (k == na)
                chk(txc == 1'b0, "R9 txc low between frames", int'(txc), 0);
            if (tx_line !== both[k]) begin
                errs++;
                if (bad_at < 0) bad_at = k;
            end
        end
        chk(errs == 0, "R9/R11 back-to-back frames (first bad index)", bad_at, -1);
        wait_tick();
        chk(txc == 1'b1, "R10 txc after second frame", int'(txc), 1);
        chk(dre == 1'b1, "R10 dre with txc", int'(dre), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule